// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block turns read and write requests into the command stream of a synchronous DRAM device. Each request names a bank, a row, a column, a direction and an auto-precharge flag. The sequencer remembers which row is open in every bank and keeps rows open between accesses. A request to the row that is already open costs one column command. A request to a closed bank costs an activate and a column command. A request that misses an open row costs a precharge, an activate and then the column command. Fixed parameter counts set the wait between these commands, and the sequencer drives NOP while it waits.

Requests enter through a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the requester must hold its fields steady and keep `req_valid` high. `req_ready` is low while an access sequence is in progress and while a refresh request is pending. A refresh request is a plain level input. It takes priority over data requests and is granted only once every bank is closed, so the sequencer first issues a precharge of all banks when any row is open. The device control pins, the address and the bank are all driven from registers.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} carry one of six codes: NOP 0111, activate 0011, precharge 0010, read 0101, write 0100, refresh 0001. NOP is driven in every cycle where no other command is issued.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Its first command appears on the pins in the cycle that follows that edge. `req_ready` is low while an access sequence runs and while `ref_req` is high. It is high again in the cycle that carries the column command.
- R3: For a request to a bank with no open row, the sequencer issues activate with the row on `sd_addr` and the bank on `sd_bank`. The column command follows T_RCD cycles later, with NOP in between. A column command only ever targets a bank whose row is open.
- R4: For a request to the row already open in its bank, only the column command is issued, in the first cycle after acceptance.
- R5: For a request to a bank holding a different open row, the sequencer issues precharge with `sd_addr` all zero. Activate follows T_RP cycles later, and the column command T_RCD cycles after the activate.
- R6: On a read or write command, `sd_addr[COL_W-1:0]` carries the column and bit AP_BIT carries the auto-precharge flag. All other address bits are zero. A write request issues write (0100) and a read request issues read (0101).
- R7: A column command with the auto-precharge flag set closes that bank's row. The next request to that bank starts with activate and no precharge.
- R8: When `ref_req` is seen in idle with any row open, the sequencer issues precharge with only bit AP_BIT of `sd_addr` set, then refresh T_RP cycles later. With no row open, refresh is issued directly. `ref_ack` is high exactly in the cycle that carries refresh. Afterwards every bank is closed.
- R9: At least T_RFC cycles of NOP follow every refresh command.
- R10: During and right after reset, the pins carry NOP, `ref_ack` is low, `req_ready` is high when `ref_req` is low, and every bank is closed.
- R11: Opening or closing a row in one bank leaves the open-row record of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| ref_req | input | 1 | Refresh wanted (level) |
| ref_ack | output | 1 | High in the cycle the refresh command is on the pins |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row, column or precharge-scope address |
| sd_bank | output | BA_W | Bank address |

## Verification
A refresh request and an access request can both be waiting in the same idle cycle. The bench raises `ref_req` and `req_valid` together in one cycle and checks that `req_ready` drops at once. It then checks that the full precharge-all and refresh sequence, with its quiet window, comes out before the held request is finally accepted and issued with the commands its bank state calls for. Random traffic also drops refresh requests between accesses while rows stay open in several banks. This makes the precharge-all path and the row-miss path both occur against the same open-row state.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    C_NOP,
    C_ACT,
    C_PRE,
    C_RD,
    C_WR,
    C_REF
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE_WAIT,
    S_ACT_WAIT,
    S_RPA_WAIT,
    S_RFC_WAIT
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] pin_code(cmd_e c);
    logic [3:0] p;
    case (c)
      C_ACT:   p = 4'b0011;
      C_PRE:   p = 4'b0010;
      C_RD:    p = 4'b0101;
      C_WR:    p = 4'b0100;
      C_REF:   p = 4'b0001;
      default: p = 4'b0111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_row_table.sv
module sdram_row_table #(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BA_W-1:0]  lk_bank,
  input  logic [ROW_W-1:0] lk_row,
  output logic             lk_open,
  output logic             lk_hit,
  output logic             any_open,
  input  logic             upd_set,
  input  logic             upd_clr,
  input  logic             upd_clr_all,
  input  logic [BA_W-1:0]  upd_bank,
  input  logic [ROW_W-1:0] upd_row
);

  logic             open_q [BANKS];
  logic [ROW_W-1:0] row_q  [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (upd_clr_all || (upd_clr && upd_bank == BA_W'(b))) begin
        open_q[b] <= 1'b0;
      end else if (upd_set && upd_bank == BA_W'(b)) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row;
      end
    end
  end

  always_comb begin
    any_open = 1'b0;
    for (int b = 0; b < BANKS; b++) any_open = any_open | open_q[b];
  end

  assign lk_open = open_q[lk_bank];
  assign lk_hit  = open_q[lk_bank] && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_in,
  input  logic [ROW_W-1:0] addr_in,
  input  logic [BA_W-1:0]  bank_in,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic [BA_W-1:0]  bank,
  output logic             ref_ack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= pin_code(C_NOP);
      addr    <= '0;
      bank    <= '0;
      ref_ack <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pin_code(cmd_in);
      addr    <= addr_in;
      bank    <= bank_in;
      ref_ack <= (cmd_in == C_REF);
    end
  end

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_RFC  = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_autopre,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             ref_req,
  output logic             req_ready,
  input  logic             lk_open,
  input  logic             lk_hit,
  input  logic             any_open,
  input  logic             t_done,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output cmd_e             iss_cmd,
  output logic [ROW_W-1:0] iss_addr,
  output logic [BA_W-1:0]  iss_bank,
  output logic             upd_set,
  output logic             upd_clr,
  output logic             upd_clr_all
);

  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(T_RFC - 1);

  seq_state_e       state_q, state_d;
  logic             take;
  logic [BA_W-1:0]  p_bank;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;
  logic             p_wr, p_ap;

  function automatic logic [ROW_W-1:0] col_word(logic [COL_W-1:0] c, logic ap);
    logic [ROW_W-1:0] w;
    w              = '0;
    w[COL_W-1:0]   = c;
    w[AP_BIT]      = ap;
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] all_banks_word();
    logic [ROW_W-1:0] w;
    w         = '0;
    w[AP_BIT] = 1'b1;
    return w;
  endfunction

  assign req_ready = (state_q == S_IDLE) && !ref_req;
  assign take      = req_ready && req_valid;

  always_comb begin
    state_d     = state_q;
    iss_cmd     = C_NOP;
    iss_addr    = '0;
    iss_bank    = '0;
    upd_set     = 1'b0;
    upd_clr     = 1'b0;
    upd_clr_all = 1'b0;
    t_load      = 1'b0;
    t_val       = '0;
    case (state_q)
      S_IDLE: begin
        if (ref_req) begin
          upd_clr_all = 1'b1;
          t_load      = 1'b1;
          if (any_open) begin
            iss_cmd  = C_PRE;
            iss_addr = all_banks_word();
            t_val    = RP_LOAD;
            state_d  = S_RPA_WAIT;
          end else begin
            iss_cmd  = C_REF;
            t_val    = RFC_LOAD;
            state_d  = S_RFC_WAIT;
          end
        end else if (req_valid) begin
          iss_bank = req_bank;
          if (lk_hit) begin
            iss_cmd  = req_write ? C_WR : C_RD;
            iss_addr = col_word(req_col, req_autopre);
            upd_clr  = req_autopre;
          end else if (lk_open) begin
            iss_cmd  = C_PRE;
            upd_clr  = 1'b1;
            t_load   = 1'b1;
            t_val    = RP_LOAD;
            state_d  = S_PRE_WAIT;
          end else begin
            iss_cmd  = C_ACT;
            iss_addr = req_row;
            upd_set  = 1'b1;
            t_load   = 1'b1;
            t_val    = RCD_LOAD;
            state_d  = S_ACT_WAIT;
          end
        end
      end
      S_PRE_WAIT: begin
        if (t_done) begin
          iss_cmd  = C_ACT;
          iss_addr = p_row;
          iss_bank = p_bank;
          upd_set  = 1'b1;
          t_load   = 1'b1;
          t_val    = RCD_LOAD;
          state_d  = S_ACT_WAIT;
        end
      end
      S_ACT_WAIT: begin
        if (t_done) begin
          iss_cmd  = p_wr ? C_WR : C_RD;
          iss_addr = col_word(p_col, p_ap);
          iss_bank = p_bank;
          upd_clr  = p_ap;
          state_d  = S_IDLE;
        end
      end
      S_RPA_WAIT: begin
        if (t_done) begin
          iss_cmd     = C_REF;
          upd_clr_all = 1'b1;
          t_load      = 1'b1;
          t_val       = RFC_LOAD;
          state_d     = S_RFC_WAIT;
        end
      end
      S_RFC_WAIT: begin
        if (t_done) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      p_bank  <= '0;
      p_row   <= '0;
      p_col   <= '0;
      p_wr    <= 1'b0;
      p_ap    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        p_bank <= req_bank;
        p_row  <= req_row;
        p_col  <= req_col;
        p_wr   <= req_write;
        p_ap   <= req_autopre;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_RFC  = 8,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_autopre,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             ref_req,
  output logic             ref_ack,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [ROW_W-1:0] sd_addr,
  output logic [BA_W-1:0]  sd_bank
);

  localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                        : ((T_RCD > T_RFC) ? T_RCD : T_RFC);
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             lk_open, lk_hit, any_open;
  logic             t_done, t_load;
  logic [CNT_W-1:0] t_val;
  cmd_e             iss_cmd;
  logic [ROW_W-1:0] iss_addr;
  logic [BA_W-1:0]  iss_bank;
  logic             upd_set, upd_clr, upd_clr_all;

  sdram_seq_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BA_W(BA_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_autopre(req_autopre),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .ref_req(ref_req), .req_ready(req_ready),
    .lk_open(lk_open), .lk_hit(lk_hit), .any_open(any_open),
    .t_done(t_done), .t_load(t_load), .t_val(t_val),
    .iss_cmd(iss_cmd), .iss_addr(iss_addr), .iss_bank(iss_bank),
    .upd_set(upd_set), .upd_clr(upd_clr), .upd_clr_all(upd_clr_all)
  );

  sdram_row_table #(.BANKS(BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_bank(req_bank), .lk_row(req_row),
    .lk_open(lk_open), .lk_hit(lk_hit), .any_open(any_open),
    .upd_set(upd_set), .upd_clr(upd_clr), .upd_clr_all(upd_clr_all),
    .upd_bank(iss_bank), .upd_row(iss_addr)
  );

  sdram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .load_val(t_val), .done(t_done)
  );

  sdram_cmd_drive #(.ROW_W(ROW_W), .BA_W(BA_W)) u_drive (
    .clk(clk), .rst_n(rst_n),
    .cmd_in(iss_cmd), .addr_in(iss_addr), .bank_in(iss_bank),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr), .bank(sd_bank), .ref_ack(ref_ack)
  );

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BANKS = 4,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RFC = 8,
  parameter int BA_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            ap_flag,
  input logic [BA_W-1:0] bank
);

  localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                        : ((T_RCD > T_RFC) ? T_RCD : T_RFC);
  localparam int SAT   = T_MAX + 1;
  localparam int CW    = $clog2(SAT + 1);

  logic [3:0] code;
  logic is_nop, is_act, is_pre, is_rd, is_wr, is_ref, is_col;
  assign code   = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (code == 4'b0111);
  assign is_act = (code == 4'b0011);
  assign is_pre = (code == 4'b0010);
  assign is_rd  = (code == 4'b0101);
  assign is_wr  = (code == 4'b0100);
  assign is_ref = (code == 4'b0001);
  assign is_col = is_rd || is_wr;

  logic [CW-1:0]    since_pre, since_act, since_ref;
  logic [BANKS-1:0] open_m, open_nx;

  function automatic logic [CW-1:0] bump(logic [CW-1:0] v);
    return (v == CW'(SAT)) ? v : v + 1'b1;
  endfunction

  always_comb begin
    open_nx = open_m;
    if (is_ref || (is_pre && ap_flag)) open_nx = '0;
    else if (is_pre)                  open_nx[bank] = 1'b0;
    else if (is_act)                  open_nx[bank] = 1'b1;
    else if (is_col && ap_flag)       open_nx[bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= CW'(SAT);
      since_act <= CW'(SAT);
      since_ref <= CW'(SAT);
      open_m    <= '0;
    end else begin
      since_pre <= is_pre ? CW'(1) : bump(since_pre);
      since_act <= is_act ? CW'(1) : bump(since_act);
      since_ref <= is_ref ? CW'(1) : bump(since_ref);
      open_m    <= open_nx;
    end
  end

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_act || is_pre || is_rd || is_wr || is_ref);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre || is_act) |-> !req_ready);

  a_r3_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= CW'(T_RCD)));

  a_r3_col_on_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> open_m[bank]);

  a_r5_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= CW'(T_RP)));

  a_r8_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (open_m == '0));

  a_r9_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> (since_ref > CW'(T_RFC)));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BANKS(BANKS), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
  .ap_flag(sd_addr[AP_BIT]), .bank(sd_bank)
);

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int BANKS  = 4;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int AP_BIT = 10;
  localparam int T_RP   = 3;
  localparam int T_RCD  = 2;
  localparam int T_RFC  = 6;
  localparam int BA_W   = 2;
  localparam int WATCHDOG = 100000;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_REF = 4'b0001;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [BA_W-1:0]  req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             ref_req = 1'b0;
  logic             req_ready, ref_ack;
  logic             sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W-1:0] sd_addr;
  logic [BA_W-1:0]  sd_bank;

  int n_chk = 0;
  int n_err = 0;

  bit               mopen [BANKS];
  logic [ROW_W-1:0] mrow  [BANKS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_seq #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC)
  ) i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .ref_req(ref_req), .ref_ack(ref_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_bank(sd_bank)
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [ROW_W-1:0] col_word(logic [COL_W-1:0] c, bit ap);
    logic [ROW_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[AP_BIT] = ap;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Drives one request from a negedge and follows its whole command sequence.
  task automatic issue(input int b, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                       input bit wr, input bit ap, input string tg);
    int pre_at, act_at, col_at;
    req_valid = 1'b1; req_bank = BA_W'(b); req_row = row; req_col = col;
    req_write = wr; req_autopre = ap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (mopen[b] && mrow[b] == row) begin pre_at = -1; act_at = -1; col_at = 0; end
    else if (mopen[b]) begin pre_at = 0; act_at = T_RP; col_at = T_RP + T_RCD; end
    else begin pre_at = -1; act_at = 0; col_at = T_RCD; end
    for (int k = 0; k <= col_at; k++) begin
      if (k > 0) @(negedge clk);
      if (k == pre_at) begin
        check({"R5 precharge code ", tg}, 32'(pins()), 32'(P_PRE));
        check({"R5 precharge addr ", tg}, 32'(sd_addr), 32'd0);
        check({"R5 precharge bank ", tg}, 32'(sd_bank), 32'(b));
      end else if (k == act_at) begin
        check({"R3 activate code ", tg}, 32'(pins()), 32'(P_ACT));
        check({"R3 activate row ", tg}, 32'(sd_addr), 32'(row));
        check({"R3 activate bank ", tg}, 32'(sd_bank), 32'(b));
      end else if (k == col_at) begin
        check({"R6 column code ", tg}, 32'(pins()), 32'(wr ? P_WR : P_RD));
        check({"R6 column addr ", tg}, 32'(sd_addr), 32'(col_word(col, ap)));
        check({"R6 column bank ", tg}, 32'(sd_bank), 32'(b));
      end else begin
        check({"R1 nop while waiting ", tg}, 32'(pins()), 32'(P_NOP));
      end
      check({"R2 ready ", tg}, 32'(req_ready), 32'(k == col_at));
    end
    mopen[b] = !ap;
    mrow[b]  = row;
  endtask

  // Called at a negedge right after ref_req was raised.
  task automatic run_refresh(input string tg);
    bit any;
    any = 1'b0;
    for (int b = 0; b < BANKS; b++) any |= mopen[b];
    @(negedge clk);
    if (any) begin
      check({"R8 precharge-all code ", tg}, 32'(pins()), 32'(P_PRE));
      check({"R8 precharge-all addr ", tg}, 32'(sd_addr), 32'(1 << AP_BIT));
      check({"R8 no ack on precharge ", tg}, 32'(ref_ack), 32'd0);
      for (int k = 1; k < T_RP; k++) begin
        @(negedge clk);
        check({"R1 nop before refresh ", tg}, 32'(pins()), 32'(P_NOP));
      end
      @(negedge clk);
    end
    check({"R8 refresh code ", tg}, 32'(pins()), 32'(P_REF));
    check({"R8 refresh ack ", tg}, 32'(ref_ack), 32'd1);
    ref_req = 1'b0;
    for (int j = 1; j <= T_RFC; j++) begin
      @(negedge clk);
      check({"R9 quiet after refresh ", tg}, 32'(pins()), 32'(P_NOP));
      check({"R8 ack is one cycle ", tg}, 32'(ref_ack), 32'd0);
      check({"R9 ready after quiet ", tg}, 32'(req_ready), 32'(j == T_RFC));
    end
    for (int b = 0; b < BANKS; b++) mopen[b] = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog: got no progress expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1badc0de));
    for (int b = 0; b < BANKS; b++) begin mopen[b] = 1'b0; mrow[b] = '0; end
    repeat (3) @(negedge clk);
    check("R10 reset pins NOP", 32'(pins()), 32'(P_NOP));
    check("R10 reset ack low", 32'(ref_ack), 32'd0);
    check("R10 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset NOP", 32'(pins()), 32'(P_NOP));

    issue(0, 13'd5, 10'd3, 1'b0, 1'b0, "R10 closed after reset");
    issue(0, 13'd5, 10'd7, 1'b1, 1'b0, "R4 row hit");
    issue(1, 13'd9, 10'd1, 1'b0, 1'b0, "R11 other bank");
    issue(0, 13'd5, 10'd8, 1'b0, 1'b0, "R11 bank0 still hit");
    issue(0, 13'd6, 10'd2, 1'b1, 1'b0, "R5 row miss");
    issue(0, 13'd6, 10'd4, 1'b0, 1'b1, "R7 autoprecharge");
    issue(0, 13'd6, 10'd5, 1'b1, 1'b0, "R7 reopen without precharge");

    ref_req = 1'b1; #1;
    check("R2 ready low on refresh", 32'(req_ready), 32'd0);
    run_refresh("with open rows");
    issue(1, 13'd9, 10'd2, 1'b0, 1'b1, "R8 closed after refresh");
    ref_req = 1'b1; #1;
    run_refresh("no open rows");

    issue(2, 13'd3, 10'd11, 1'b1, 1'b0, "R3 open bank2");
    ref_req = 1'b1;
    req_valid = 1'b1; req_bank = 2'd2; req_row = 13'd4; req_col = 10'd9;
    req_write = 1'b0; req_autopre = 1'b0; #1;
    check("R2 collision ready low", 32'(req_ready), 32'd0);
    run_refresh("collision");
    issue(2, 13'd4, 10'd9, 1'b0, 1'b0, "R2 held request after refresh");
    issue(2, 13'd4, 10'd10, 1'b1, 1'b0, "R4 back to back 1");
    issue(2, 13'd4, 10'd12, 1'b0, 1'b0, "R4 back to back 2");

    for (int n = 0; n < 300; n++) begin
      int b;
      logic [ROW_W-1:0] r;
      b = int'($urandom % BANKS);
      r = ($urandom % 4 == 0) ? ROW_W'($urandom) : ROW_W'($urandom % 3);
      issue(b, r, COL_W'($urandom), bit'($urandom % 2), bit'($urandom % 4 == 0), "random");
      if ($urandom % 16 == 0) begin
        ref_req = 1'b1; #1;
        check("R2 random ready low on refresh", 32'(req_ready), 32'd0);
        run_refresh("random");
      end
    end

    summary();
    $finish;
  end

endmodule